// File: doc/BRIEF.md
# Lane-Segmented Integer Multiplier

This block multiplies two 64-bit operands on one shared partial-product array that can be cut, at run time, into one, two, four or eight independent lanes. A 2-bit lane-mode input picks the arrangement, and a signedness input picks two's-complement or unsigned operands for every lane. Each lane returns its full double-width product, and the lane products are packed side by side into a single 128-bit result. In every mode the result is filled exactly.

The array is masked so that a lane only sees partial products from its own diagonal block. The adder that sums the rows stops carries at every product-lane boundary, so no lane can disturb its neighbours. Operands, mode and signedness are captured together when the input strobe is high. The result appears two clock edges later with an output strobe. There is no backpressure.

Top module: `pmul_top`

## Requirements
- R1: With inMode = 2'b00, outProd holds the full 128-bit product of inA and inB.
- R2: With inMode = 2'b01, lane k (k = 0..1) takes bits [32k +: 32] of each operand, and its 64-bit product lands in outProd[64k +: 64].
- R3: With inMode = 2'b10, lane k (k = 0..3) takes bits [16k +: 16], and its 32-bit product lands in outProd[32k +: 32].
- R4: With inMode = 2'b11, lane k (k = 0..7) takes bits [8k +: 8], and its 16-bit product lands in outProd[16k +: 16].
- R5: With inSigned = 1, each lane operand is read as two's complement and sign-extended from that lane's own top bit. With inSigned = 0, each lane operand is read as unsigned.
- R6: A lane's product depends only on that lane's operand bits. Carries and partial products never cross a lane boundary, even when every lane produces its largest product.
- R7: In signed mode, the most negative lane value multiplied by itself gives the exact positive double-width product (for example, -128 x -128 = 16384 in an 8-bit lane).
- R8: When inValid is high at a rising edge, outValid is high after the next rising edge and shows that operation's result. When inValid is low, outValid is low two edges later. Back-to-back operations are accepted on every cycle.
- R9: A synchronous active-high rst clears outValid and the result register to zero at the next rising edge.
- R10: When no valid input is captured, the result register keeps its value. Changing the operands, mode or signedness while inValid is low has no effect on outProd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands, mode and signedness are valid this cycle |
| inMode | input | 2 | Lane arrangement: 00 = 1x64, 01 = 2x32, 10 = 4x16, 11 = 8x8 |
| inSigned | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| inA | input | 64 | First operand, packed lanes |
| inB | input | 64 | Second operand, packed lanes |
| outValid | output | 1 | outProd carries a new result |
| outProd | output | 128 | Packed double-width lane products |

## Verification
The bench targets the points where a segmented multiplier usually breaks:
- The most negative lane value squared in signed mode. A design that sign-extends at bit 63, or that drops the top product bit, returns a negative or truncated lane.
- All-ones operands in unsigned mode, which push a full carry into every lane top. A design that lets a carry cross a boundary corrupts the lane above.
- Mode and signedness changing from one cycle to the next, and junk on the inputs while inValid is low. A pipeline that samples these controls late, or that reloads the result without a valid input, shows a wrong or changed result.
- A reset in the middle of traffic, which must drop any operation still in flight.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    LANES_1 = 2'b00,
    LANES_2 = 2'b01,
    LANES_4 = 2'b10,
    LANES_8 = 2'b11
  } lane_mode_e;

  typedef struct packed {
    logic       loadOps;
    logic       loadRes;
    lane_mode_e mode;
    logic       signedOps;
  } pmul_strobe_t;

endpackage

// File: rtl/pmul_ctrl.sv
module pmul_ctrl
  import pmul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   inMode,
  input  logic         inSigned,
  output pmul_strobe_t strobe,
  output logic         outValid
);

  logic       s1Valid;
  logic       outValidQ;
  lane_mode_e s1Mode;
  logic       s1Signed;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid   <= 1'b0;
      outValidQ <= 1'b0;
      s1Mode    <= LANES_1;
      s1Signed  <= 1'b0;
    end else begin
      s1Valid   <= inValid;
      outValidQ <= s1Valid;
      if (inValid) begin
        s1Mode   <= lane_mode_e'(inMode);
        s1Signed <= inSigned;
      end
    end
  end

  always_comb begin
    strobe.loadOps   = inValid;
    strobe.loadRes   = s1Valid;
    strobe.mode      = s1Mode;
    strobe.signedOps = s1Signed;
  end

  assign outValid = outValidQ;

endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
  import pmul_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pmul_strobe_t          strobe,
  input  logic [DATA_W-1:0]     inA,
  input  logic [DATA_W-1:0]     inB,
  output logic [2*DATA_W-1:0]   outProd
);

  localparam int PROD_W   = 2 * DATA_W;
  localparam int LOG_W    = $clog2(DATA_W);
  localparam int MIN_LANE = DATA_W / 8;
  localparam int CHUNK_W  = 2 * MIN_LANE;
  localparam int N_CHUNK  = PROD_W / CHUNK_W;

  logic [DATA_W-1:0]  opA, opB;
  logic [PROD_W-1:0]  aExt, bExt;
  logic [PROD_W-1:0]  prodNext, resQ;
  logic [N_CHUNK-1:0] chunkStart;
  int                 shiftW;

  // Operand stage: captured only with a valid input.
  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
    end else if (strobe.loadOps) begin
      opA <= inA;
      opB <= inB;
    end
  end

  // log2 of the product-lane width for the current mode
  always_comb shiftW = LOG_W + 1 - int'(strobe.mode);

  // A chunk starts a product lane when its base is a multiple of the lane width.
  for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
    localparam int BASE = c * CHUNK_W;
    assign chunkStart[c] = (((BASE >> shiftW) << shiftW) == BASE);
  end

  // Segmented adder: the carry is killed at every lane start.
  function automatic logic [PROD_W-1:0] segAdd(
    input logic [PROD_W-1:0]  x,
    input logic [PROD_W-1:0]  y,
    input logic [N_CHUNK-1:0] starts
  );
    logic [CHUNK_W:0] part;
    logic             cy;
    cy = 1'b0;
    for (int c = 0; c < N_CHUNK; c++) begin
      part = {1'b0, x[c*CHUNK_W +: CHUNK_W]} + {1'b0, y[c*CHUNK_W +: CHUNK_W]}
           + {{CHUNK_W{1'b0}}, cy & ~starts[c]};
      segAdd[c*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
      cy = part[CHUNK_W];
    end
  endfunction

  // Widen every lane operand to its product-lane width (sign or zero fill).
  always_comb begin
    int laneW, lane, pos, src;
    aExt  = '0;
    bExt  = '0;
    laneW = 1 << (shiftW - 1);
    for (int q = 0; q < PROD_W; q++) begin
      lane = q >> shiftW;
      pos  = q - (lane << shiftW);
      if (pos < laneW) begin
        src     = lane * laneW + pos;
        aExt[q] = opA[src];
        bExt[q] = opB[src];
      end else begin
        src     = lane * laneW + laneW - 1;
        aExt[q] = strobe.signedOps & opA[src];
        bExt[q] = strobe.signedOps & opB[src];
      end
    end
  end

  // Shared partial-product array, masked to the diagonal lane blocks.
  always_comb begin
    logic [PROD_W-1:0] laneMask, row, acc;
    int                base, pos;
    acc = '0;
    for (int r = 0; r < PROD_W; r++) begin
      base = (r >> shiftW) << shiftW;
      pos  = r - base;
      for (int q = 0; q < PROD_W; q++) begin
        laneMask[q] = ((q >> shiftW) == (r >> shiftW));
      end
      row = ((aExt & laneMask) << pos) & laneMask;
      if (bExt[r]) begin
        acc = segAdd(acc, row, chunkStart);
      end
    end
    prodNext = acc;
  end

  // Result stage: reloaded only when a captured operation reaches it.
  always_ff @(posedge clk) begin
    if (rst) begin
      resQ <= '0;
    end else if (strobe.loadRes) begin
      resQ <= prodNext;
    end
  end

  assign outProd = resQ;

endmodule

// File: rtl/pmul_top.sv
module pmul_top
  import pmul_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        inMode,
  input  logic              inSigned,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [PROD_W-1:0] outProd
);

  pmul_strobe_t strobe;

  pmul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inMode   (inMode),
    .inSigned (inSigned),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pmul_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inA     (inA),
    .inB     (inB),
    .outProd (outProd)
  );

endmodule

// File: rtl/pmul_checker.sv
module pmul_checker #(
  parameter int PROD_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [PROD_W-1:0] outProd
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !outValid); // R9

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 $stable(outProd)); // R10

endmodule

bind pmul_top pmul_checker #(.PROD_W(PROD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outProd  (outProd)
);

// File: tb/test_pmul_top.sv
`timescale 1ns/1ps
module test_pmul_top;

  localparam int DW = 64;
  localparam int PW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [1:0]    inMode = 2'b00;
  logic          inSigned = 1'b0;
  logic [DW-1:0] inA = '0;
  logic [DW-1:0] inB = '0;
  logic          outValid;
  logic [PW-1:0] outProd;

  always #2.5 clk = ~clk;

  pmul_top #(.DATA_W(DW)) i_pmul_top (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode),
    .inSigned(inSigned), .inA(inA), .inB(inB),
    .outValid(outValid), .outProd(outProd)
  );

  int nChecks = 0;
  int nFails  = 0;

  // behavioural two-stage reference
  logic          m1Valid = 1'b0;
  logic [PW-1:0] m1Exp = '0;
  string         m1Tag = "R9";
  logic          mOutValid = 1'b0;
  logic [PW-1:0] mOutExp = '0;
  string         mOutTag = "R9";

  string modeTag[4] = '{"R1", "R2", "R3", "R4"};

  function automatic logic [PW-1:0] refMul(input int mode, input logic sgn,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
    int n, lanes;
    logic [PW-1:0] mask, pmask, aX, bX, p, res;
    n = DW >> mode;
    lanes = 1 << mode;
    mask  = {PW{1'b1}} >> (PW - n);
    pmask = {PW{1'b1}} >> (PW - 2*n);
    res = '0;
    for (int k = 0; k < lanes; k++) begin
      aX = ({{DW{1'b0}}, a} >> (k*n)) & mask;
      bX = ({{DW{1'b0}}, b} >> (k*n)) & mask;
      if (sgn && aX[n-1]) aX = aX | ~mask;
      if (sgn && bX[n-1]) bX = bX | ~mask;
      p = aX * bX;
      res = res | ((p & pmask) << (2*n*k));
    end
    return res;
  endfunction

  function automatic logic [DW-1:0] minNeg(input int mode);
    int n;
    logic [DW-1:0] v;
    n = DW >> mode;
    for (int q = 0; q < DW; q++) v[q] = ((q % n) == n - 1);
    return v;
  endfunction

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // One clock: drive after a falling edge, model the rising edge, check at the next falling edge.
  task automatic cycle(input logic v, input int mode, input logic sgn,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
    logic [PW-1:0] e;
    inValid = v; inMode = 2'(mode); inSigned = sgn; inA = a; inB = b;
    e = refMul(mode, sgn, a, b);
    @(posedge clk);
    if (rst) begin
      mOutValid = 1'b0; mOutExp = '0; m1Valid = 1'b0; mOutTag = "R9";
    end else begin
      if (m1Valid) begin mOutExp = m1Exp; mOutTag = m1Tag; end
      else mOutTag = "R10";
      mOutValid = m1Valid;
      m1Valid = v;
      if (v) begin m1Exp = e; m1Tag = tag; end
    end
    @(negedge clk);
    nChecks++;
    if (outValid !== mOutValid) begin
      nFails++;
      $display("FAIL %s outValid: actual %0b expected %0b", rst ? "R9" : "R8", outValid, mOutValid);
    end
    nChecks++;
    if (outProd !== mOutExp) begin
      nFails++;
      $display("FAIL %s outProd: actual %h expected %h", mOutTag, outProd, mOutExp);
    end
  endtask

  task automatic runMode(input int mode, input logic sgn);
    string t;
    t = sgn ? {modeTag[mode], " R5"} : modeTag[mode];
    if (sgn) cycle(1'b1, mode, sgn, minNeg(mode), minNeg(mode), "R7");
    cycle(1'b1, mode, sgn, '1, '1, "R6");
    cycle(1'b1, mode, sgn, '0, rnd64(), t);
    cycle(1'b1, mode, sgn, {DW/8{8'h01}}, '1, t);
    cycle(1'b1, mode, sgn, minNeg(mode), '1, t);
    for (int i = 0; i < 16; i++) begin
      if ($urandom_range(0, 3) == 0)
        cycle(1'b0, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), rnd64(), rnd64(), "R10");
      cycle(1'b1, mode, sgn, rnd64(), rnd64(), t);
    end
  endtask

  task automatic doReset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0, '0, '0, "R9");
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(3);
    for (int m = 0; m < 4; m++) begin
      runMode(m, 1'b0);
      runMode(m, 1'b1);
    end
    // controls switching every cycle (R5, R8)
    for (int i = 0; i < 24; i++)
      cycle(1'b1, i % 4, 1'(i / 4 % 2), rnd64(), rnd64(), "R8 R5");
    // idle with junk inputs keeps the last result (R10)
    for (int i = 0; i < 6; i++)
      cycle(1'b0, i % 4, 1'(i % 2), rnd64(), rnd64(), "R10");
    // reset while operations are in flight (R9)
    cycle(1'b1, 3, 1'b1, rnd64(), rnd64(), "R4");
    cycle(1'b1, 2, 1'b0, rnd64(), rnd64(), "R3");
    doReset(2);
    cycle(1'b0, 0, 1'b0, rnd64(), rnd64(), "R10");
    cycle(1'b1, 0, 1'b1, minNeg(0), minNeg(0), "R7");
    cycle(1'b0, 0, 1'b0, '0, '0, "R10");
    cycle(1'b0, 0, 1'b0, '0, '0, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule